// File: doc/BRIEF.md
# Dual-Channel Waveform Readout and Measurement Engine

This block sits on the read side of a 1024-entry, 8-bit capture memory that holds two interleaved channels. Channel A is at the odd addresses and channel B is at the even addresses. Each display pass works in a fixed order. First it sends channel A's vertical position word to a 16-bit serial DAC. Then it reads all 512 channel A samples. Then it sends channel B's position word. Then it reads all 512 channel B samples. Every sample that is read comes out as a pixel. The pixel's horizontal coordinate is the sample index and its vertical coordinate is the stored value. The analog DAC output offsets each trace, so the two traces can be moved up and down independently.

A host-set start offset, counted in sample pairs, rotates the read window. This pans the trace horizontally. While a pass runs, the engine collects the minimum, maximum and sum of each channel. At the end of the pass it latches peak-to-peak and mean registers that the host can read. Passes repeat for as long as `run` is held high. A pass that has started always runs to its end.

Top module: `wave_readout`

## Requirements
- R1: After reset, `dac_cs_n` is 1, `dac_sck` is 0, `pix_valid` and `meas_valid` are 0, and all four measurement outputs are 0.
- R2: The channel A sample with index i is read from address 2·((i + base) mod 512) + 1. The channel B sample with index i is read from address 2·((i + base) mod 512). Here base is the value of `base_pair` at the start of the pass.
- R3: In each pass the block emits 512 pixels with `pix_chan`=0 (channel A), then 512 pixels with `pix_chan`=1 (channel B). Within each channel, `row_x` runs from 0 to 511 on consecutive cycles.
- R4: `col_y` of each pixel equals the memory word at that pixel's R2 address. The memory returns data one cycle after the address.
- R5: Each DAC frame holds `dac_cs_n` low for exactly 16 bits, sent MSB first. `dac_sdo` is stable while `dac_sck` is high, the DAC samples on the rising edge, and rising edges are 4 clocks apart. `dac_sck` is low whenever `dac_cs_n` is high.
- R6: The frame carrying `pos_a` completes before the first channel A pixel. The frame carrying `pos_b` starts after the last channel A address is issued and completes before the first channel B pixel.
- R7: At the end of each pass, `meas_valid` pulses for one cycle. At the same time `pp_a`/`pp_b` take the value max − min of that channel's 512 samples.
- R8: At the same time, `avg_a`/`avg_b` take floor(sum of the channel's 512 samples / 512).
- R9: When `run` is low at the end of a pass, the block goes idle. It emits no pixel and no DAC frame, and the measurement outputs hold their values.
- R10: A change of `base_pair` during a pass has no effect on that pass's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start or continue display passes |
| base_pair | input | 9 | Horizontal start offset in sample pairs |
| pos_a | input | 16 | Vertical position word for channel A |
| pos_b | input | 16 | Vertical position word for channel B |
| rd_addr | output | 10 | Capture memory read address |
| rd_data | input | 8 | Capture memory read data, one cycle after address |
| pix_valid | output | 1 | Pixel outputs valid this cycle |
| pix_chan | output | 1 | Pixel channel: 0 = A, 1 = B |
| row_x | output | 9 | Horizontal scan value (sample index) |
| col_y | output | 8 | Vertical scan value (sample) |
| dac_cs_n | output | 1 | DAC frame select, active low |
| dac_sck | output | 1 | DAC serial clock |
| dac_sdo | output | 1 | DAC serial data, MSB first |
| meas_valid | output | 1 | One-cycle pulse when results are updated |
| pp_a | output | 8 | Channel A peak-to-peak |
| avg_a | output | 8 | Channel A mean |
| pp_b | output | 8 | Channel B peak-to-peak |
| avg_b | output | 8 | Channel B mean |

## Verification
The assertions assume three things about the inputs. The memory answers an address on the very next cycle. `run` is low or high as a level and is never pulsed. The position words are sampled only when their frame is loaded. The bench's memory model reads on the clock edge with exactly that one-cycle latency. The bench rewrites memory contents and position words only while the block is idle, and it lowers `run` as soon as a pass has begun, so each pass is seen in isolation. Only `base_pair` is deliberately moved during a pass, to show that the captured offset is kept.

// File: rtl/wave_readout_pkg.sv
package wave_readout_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POS_A,
        ST_SCAN_A,
        ST_POS_B,
        ST_SCAN_B,
        ST_DRAIN,
        ST_LATCH
    } rd_state_e;

endpackage

// File: rtl/wave_pos_serializer.sv
module wave_pos_serializer #(
    parameter int WORD_W  = 16,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              done,
    output logic              cs_n,
    output logic              sck,
    output logic              sdo
);
    localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam int HALF  = CLK_DIV / 2;

    typedef struct packed {
        logic              active;
        logic [WORD_W-1:0] shreg;
        logic [BIT_W-1:0]  bitn;
        logic [PH_W-1:0]   phase;
    } ser_t;

    ser_t s_d, s_q;
    logic last_phase;
    logic last_bit;

    assign last_phase = (s_q.phase == PH_W'(CLK_DIV - 1));
    assign last_bit   = (s_q.bitn == BIT_W'(WORD_W - 1));
    assign done       = s_q.active && last_phase && last_bit;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.active = 1'b1;
            s_d.shreg  = word;
            s_d.bitn   = '0;
            s_d.phase  = '0;
        end else if (s_q.active) begin
            if (last_phase) begin
                s_d.phase = '0;
                if (last_bit) begin
                    s_d.active = 1'b0;
                end else begin
                    s_d.shreg = {s_q.shreg[WORD_W-2:0], 1'b0};
                    s_d.bitn  = BIT_W'(s_q.bitn + 1'b1);
                end
            end else begin
                s_d.phase = PH_W'(s_q.phase + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n = ~s_q.active;
    assign sck  = s_q.active && (s_q.phase >= PH_W'(HALF));
    assign sdo  = s_q.active && s_q.shreg[WORD_W-1];

endmodule

// File: rtl/wave_chan_meas.sv
module wave_chan_meas #(
    parameter int DATA_W  = 8,
    parameter int CNT_LOG = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              latch,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp,
    output logic [DATA_W-1:0] pk2pk,
    output logic [DATA_W-1:0] mean
);
    localparam int SUM_W = DATA_W + CNT_LOG;

    typedef struct packed {
        logic [DATA_W-1:0] mn;
        logic [DATA_W-1:0] mx;
        logic [SUM_W-1:0]  sum;
        logic [DATA_W-1:0] pp;
        logic [DATA_W-1:0] avg;
    } meas_t;

    meas_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (clear) begin
            m_d.mn  = '1;
            m_d.mx  = '0;
            m_d.sum = '0;
        end else if (smp_vld) begin
            if (smp < m_q.mn) m_d.mn = smp;
            if (smp > m_q.mx) m_d.mx = smp;
            m_d.sum = m_q.sum + SUM_W'(smp);
        end
        if (latch) begin
            m_d.pp  = m_q.mx - m_q.mn;
            m_d.avg = DATA_W'(m_q.sum >> CNT_LOG);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.mn  <= '1;
            m_q.mx  <= '0;
            m_q.sum <= '0;
            m_q.pp  <= '0;
            m_q.avg <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign pk2pk = m_q.pp;
    assign mean  = m_q.avg;

endmodule

// File: rtl/wave_readout.sv
module wave_readout
    import wave_readout_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int DAC_W   = 16,
    parameter int CLK_DIV = 4,
    localparam int IDX_W  = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [IDX_W-1:0]  base_pair,
    input  logic [DAC_W-1:0]  pos_a,
    input  logic [DAC_W-1:0]  pos_b,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              pix_valid,
    output logic              pix_chan,
    output logic [IDX_W-1:0]  row_x,
    output logic [DATA_W-1:0] col_y,
    output logic              dac_cs_n,
    output logic              dac_sck,
    output logic              dac_sdo,
    output logic              meas_valid,
    output logic [DATA_W-1:0] pp_a,
    output logic [DATA_W-1:0] avg_a,
    output logic [DATA_W-1:0] pp_b,
    output logic [DATA_W-1:0] avg_b
);
    localparam int N_CH = 2;
    localparam logic [IDX_W-1:0] IDX_LAST = '1;

    typedef struct packed {
        rd_state_e         state;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  base;
        logic              s1_vld;
        logic [IDX_W-1:0]  s1_idx;
        logic              s1_chan;
        logic              pix_vld;
        logic [IDX_W-1:0]  row;
        logic [DATA_W-1:0] col;
        logic              chan;
        logic              mvalid;
    } rd_t;

    rd_t r_d, r_q;

    logic             ser_load;
    logic [DAC_W-1:0] ser_word;
    logic             ser_done;
    logic             meas_clear;
    logic             meas_latch;

    logic [DATA_W-1:0] pp_w  [N_CH];
    logic [DATA_W-1:0] avg_w [N_CH];

    // A pass-start helper shared by the idle and latch states.
    function automatic void start_pass(inout rd_t n, output logic ld,
                                       output logic clr);
        n.state = ST_POS_A;
        n.base  = base_pair;
        ld      = 1'b1;
        clr     = 1'b1;
    endfunction

    always_comb begin
        r_d        = r_q;
        ser_load   = 1'b0;
        ser_word   = pos_a;
        meas_clear = 1'b0;
        meas_latch = 1'b0;

        // Output pipeline: memory word arrives one cycle after its address.
        r_d.s1_vld  = 1'b0;
        r_d.pix_vld = r_q.s1_vld;
        r_d.row     = r_q.s1_idx;
        r_d.chan    = r_q.s1_chan;
        r_d.col     = r_q.s1_vld ? rd_data : r_q.col;
        r_d.mvalid  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (run) start_pass(r_d, ser_load, meas_clear);
            end
            ST_POS_A: begin
                if (ser_done) begin
                    r_d.state = ST_SCAN_A;
                    r_d.idx   = '0;
                end
            end
            ST_SCAN_A: begin
                r_d.s1_vld  = 1'b1;
                r_d.s1_idx  = r_q.idx;
                r_d.s1_chan = 1'b0;
                if (r_q.idx == IDX_LAST) begin
                    r_d.state = ST_POS_B;
                    ser_load  = 1'b1;
                    ser_word  = pos_b;
                end else begin
                    r_d.idx = IDX_W'(r_q.idx + 1'b1);
                end
            end
            ST_POS_B: begin
                if (ser_done) begin
                    r_d.state = ST_SCAN_B;
                    r_d.idx   = '0;
                end
            end
            ST_SCAN_B: begin
                r_d.s1_vld  = 1'b1;
                r_d.s1_idx  = r_q.idx;
                r_d.s1_chan = 1'b1;
                if (r_q.idx == IDX_LAST) begin
                    r_d.state = ST_DRAIN;
                end else begin
                    r_d.idx = IDX_W'(r_q.idx + 1'b1);
                end
            end
            ST_DRAIN: begin
                r_d.state = ST_LATCH;
            end
            ST_LATCH: begin
                meas_latch = 1'b1;
                r_d.mvalid = 1'b1;
                if (run) begin
                    start_pass(r_d, ser_load, meas_clear);
                end else begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // Channel A lives at odd addresses, channel B at even ones.
    assign rd_addr = {IDX_W'(r_q.idx + r_q.base), (r_q.state == ST_SCAN_A)};

    wave_pos_serializer #(
        .WORD_W (DAC_W),
        .CLK_DIV(CLK_DIV)
    ) u_ser (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ser_load),
        .word (ser_word),
        .done (ser_done),
        .cs_n (dac_cs_n),
        .sck  (dac_sck),
        .sdo  (dac_sdo)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_meas
        wave_chan_meas #(
            .DATA_W (DATA_W),
            .CNT_LOG(IDX_W)
        ) u_meas (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (meas_clear),
            .latch  (meas_latch),
            .smp_vld(r_q.s1_vld && (r_q.s1_chan == 1'(ch))),
            .smp    (rd_data),
            .pk2pk  (pp_w[ch]),
            .mean   (avg_w[ch])
        );
    end

    assign pix_valid  = r_q.pix_vld;
    assign pix_chan   = r_q.chan;
    assign row_x      = r_q.row;
    assign col_y      = r_q.col;
    assign meas_valid = r_q.mvalid;
    assign pp_a       = pp_w[0];
    assign avg_a      = avg_w[0];
    assign pp_b       = pp_w[1];
    assign avg_b      = avg_w[1];

endmodule

// File: rtl/wave_readout_chk.sv
module wave_readout_chk #(
    parameter int IDX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             pix_chan,
    input logic [IDX_W-1:0] row_x,
    input logic             dac_cs_n,
    input logic             dac_sck,
    input logic             dac_sdo,
    input logic             meas_valid
);

    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sck);

    assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && dac_sck && $past(dac_sck) && !$past(dac_cs_n))
        |-> $stable(dac_sdo));

    assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && (pix_chan == $past(pix_chan)))
        |-> (row_x == IDX_W'($past(row_x) + 1'b1)));

    assert_chan_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && $past(pix_chan)) |-> pix_chan);

    assert_frame_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> dac_cs_n);

    assert_meas_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

endmodule

bind wave_readout wave_readout_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_chan  (pix_chan),
    .row_x     (row_x),
    .dac_cs_n  (dac_cs_n),
    .dac_sck   (dac_sck),
    .dac_sdo   (dac_sdo),
    .meas_valid(meas_valid)
);

// File: tb/wave_readout_bench.sv
module wave_readout_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [8:0]  base_pair = '0;
    logic [15:0] pos_a = '0;
    logic [15:0] pos_b = '0;
    logic [9:0]  rd_addr;
    logic [7:0]  rd_data = '0;
    logic        pix_valid, pix_chan;
    logic [8:0]  row_x;
    logic [7:0]  col_y;
    logic        dac_cs_n, dac_sck, dac_sdo, meas_valid;
    logic [7:0]  pp_a, avg_a, pp_b, avg_b;

    always #4 clk = ~clk;

    wave_readout u_wave_readout (
        .clk(clk), .rst_n(rst_n), .run(run), .base_pair(base_pair),
        .pos_a(pos_a), .pos_b(pos_b), .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_valid(pix_valid), .pix_chan(pix_chan), .row_x(row_x),
        .col_y(col_y), .dac_cs_n(dac_cs_n), .dac_sck(dac_sck),
        .dac_sdo(dac_sdo), .meas_valid(meas_valid), .pp_a(pp_a),
        .avg_a(avg_a), .pp_b(pp_b), .avg_b(avg_b)
    );

    logic [7:0] mem [0:1023];
    always @(posedge clk) rd_data <= mem[rd_addr];

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // per-pass monitor state
    bit      in_pass = 0;
    int      base_exp = 0;
    int      cnt_a, cnt_b, order_err, data_err, seq_err, idle_err;
    int      frames, bitn, bit_err, per_err, since_rise, mv_cnt;
    logic [15:0] shw;
    logic [15:0] words [0:1];
    logic [7:0]  got_pp_a, got_avg_a, got_pp_b, got_avg_b;
    logic        sck_prev = 0, cs_prev = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            since_rise++;
            if (!in_pass && (pix_valid || !dac_cs_n)) idle_err++;
            if (pix_valid) begin
                int a;
                a = 2 * ((int'(row_x) + base_exp) % 512) + (pix_chan ? 0 : 1);
                if (col_y != mem[a]) data_err++;
                if (!pix_chan) begin
                    if (cnt_a == 0 && frames != 1) seq_err++;
                    if (cnt_b != 0 || int'(row_x) != cnt_a) order_err++;
                    cnt_a++;
                end else begin
                    if (cnt_b == 0 && frames != 2) seq_err++;
                    if (cnt_a != 512 || int'(row_x) != cnt_b) order_err++;
                    cnt_b++;
                end
            end
            if (cs_prev && !dac_cs_n) begin
                bitn = 0;
                shw = '0;
            end
            if (!dac_cs_n && dac_sck && !sck_prev) begin
                if (bitn > 0 && since_rise != 4) per_err++;
                since_rise = 0;
                shw = {shw[14:0], dac_sdo};
                bitn++;
            end
            if (!cs_prev && dac_cs_n) begin
                if (bitn != 16) bit_err++;
                if (frames < 2) words[frames] = shw;
                if (frames == 1 && (cnt_a != 512 || cnt_b != 0)) seq_err++;
                frames++;
            end
            if (meas_valid) begin
                mv_cnt++;
                got_pp_a = pp_a; got_avg_a = avg_a;
                got_pp_b = pp_b; got_avg_b = avg_b;
            end
            sck_prev = dac_sck;
            cs_prev  = dac_cs_n;
        end
    end

    task automatic fill(input int kind, input int seed);
        int s = seed;
        for (int i = 0; i < 1024; i++) begin
            case (kind)
                0: mem[i] = 8'(i * 3 + seed);
                1: begin s = s * 1103515245 + 12345; mem[i] = 8'(s >>> 16); end
                2: mem[i] = 8'h5A;
                default: mem[i] = (i % 2 == 1) ? 8'hFF : 8'h00;
            endcase
        end
    endtask

    task automatic do_pass(input int b, input logic [15:0] pa,
                           input logic [15:0] pb, input bit move_base);
        int mn_a = 255, mx_a = 0, sm_a = 0, mn_b = 255, mx_b = 0, sm_b = 0;
        for (int i = 0; i < 512; i++) begin
            int va = mem[2*i+1];
            int vb = mem[2*i];
            if (va < mn_a) mn_a = va;
            if (va > mx_a) mx_a = va;
            if (vb < mn_b) mn_b = vb;
            if (vb > mx_b) mx_b = vb;
            sm_a += va; sm_b += vb;
        end
        @(negedge clk);
        cnt_a = 0; cnt_b = 0; order_err = 0; data_err = 0; seq_err = 0;
        frames = 0; bitn = 0; bit_err = 0; per_err = 0; mv_cnt = 0;
        idle_err = 0; words[0] = '0; words[1] = '0;
        base_exp = b; base_pair = 9'(b); pos_a = pa; pos_b = pb;
        in_pass = 1; run = 1;
        @(negedge clk);
        run = 0;
        if (move_base) base_pair = 9'(b + 77);
        while (mv_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        in_pass = 0;
        chk(cnt_a == 512 && cnt_b == 512, "R3", "pixel count a*1000+b",
            cnt_a * 1000 + cnt_b, 512512);
        chk(order_err == 0, "R3", "row/channel order errors", order_err, 0);
        chk(data_err == 0, move_base ? "R10" : "R2/R4 address+data (R2 R4)",
            "column mismatches", data_err, 0);
        chk(frames == 2 && bit_err == 0 && per_err == 0, "R5",
            "frames*100+bit_err*10+per_err", frames*100+bit_err*10+per_err, 200);
        chk(words[0] == pa, "R6", "frame A word", words[0], pa);
        chk(words[1] == pb, "R6", "frame B word", words[1], pb);
        chk(seq_err == 0, "R6", "frame/pixel ordering errors", seq_err, 0);
        chk(mv_cnt == 1, "R7", "meas_valid pulses", mv_cnt, 1);
        chk(got_pp_a == 8'(mx_a - mn_a), "R7", "pp_a", got_pp_a, mx_a - mn_a);
        chk(got_pp_b == 8'(mx_b - mn_b), "R7", "pp_b", got_pp_b, mx_b - mn_b);
        chk(got_avg_a == 8'(sm_a / 512), "R8", "avg_a", got_avg_a, sm_a / 512);
        chk(got_avg_b == 8'(sm_b / 512), "R8", "avg_b", got_avg_b, sm_b / 512);
        repeat (150) @(negedge clk);
        chk(idle_err == 0, "R9", "activity while idle", idle_err, 0);
        chk(pp_a == got_pp_a && avg_b == got_avg_b, "R9", "held result pp_a",
            pp_a, got_pp_a);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        fill(0, 0);
        repeat (3) @(negedge clk);
        chk(dac_cs_n == 1 && dac_sck == 0, "R1", "cs_n*2+sck", dac_cs_n*2+dac_sck, 2);
        chk(!pix_valid && !meas_valid, "R1", "pix_valid|meas_valid", pix_valid|meas_valid, 0);
        chk({pp_a, avg_a, pp_b, avg_b} == '0, "R1", "measurements", pp_a | avg_a | pp_b | avg_b, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        do_pass(0,   16'hA55A, 16'h0F0F, 0);
        fill(1, 7);
        do_pass(1,   16'h8001, 16'h7FFE, 0);
        fill(0, 13);
        do_pass(300, 16'hFFFF, 16'h0000, 0);
        fill(2, 0);
        do_pass(511, 16'h1234, 16'hFEDC, 0);
        fill(3, 0);
        do_pass(128, 16'h0001, 16'h8000, 0);
        fill(1, 99);
        do_pass(45,  16'hC3C3, 16'h3C3C, 1);
        finish_run();
    end
endmodule